// File: doc/BRIEF.md
# Capture holding-register latch unit

This block keeps four input-capture channels. Each channel stores the timer value on a capture event and counts qualified edges in an 8-bit accumulator. Each channel also has a holding pair, one word for the capture value and one byte for the count, which the bus reads. The free-running timer lies outside the block, and its current value arrives on an input port.

Software takes a coherent snapshot of all four channels by writing a one to a force bit. The write counts only when the latch-mode enable and the buffer enable are both high. In that case every capture value and every edge count moves into its holding pair on the same clock edge, and all four accumulators go back to zero. In any other case the write is dropped and not kept for later. The force bit always reads back as zero.

Top module: `cpl_latch_unit`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, every capture register, accumulator and holding register reads zero.
- R2: A high on `cap_evt[i]` loads `timer_val` into the capture register of channel i at the next clock edge. With no event, the register keeps its value.
- R3: A high on `acc_evt[i]` raises the accumulator of channel i by one at the next edge. At 0xFF it stays at 0xFF and does not wrap.
- R4: A write cycle (`force_wr` high) with `force_wdata` at 1, while `mode_latch_en` and `mode_buf_en` are both high, copies all four capture values into `hold_cap_o` and all four counts into `hold_acc_o` at the same edge.
- R5: The edge that performs a forced latch also clears all four accumulators to zero.
- R6: A force write made while either enable is low changes no register. It is not stored, so enables set on a later cycle without a new write cause no latch.
- R7: A force write with `force_wdata` at 0 has no effect.
- R8: `force_rd_bit` always reads 0.
- R9: If a capture event and a forced latch fall in the same cycle, the holding register receives the new timer value. An accumulator edge in that cycle is included in the latched count (saturating), and the accumulator still clears.
- R10: Holding registers change only on a forced latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_latch_en | input | 1 | Latch-mode enable |
| mode_buf_en | input | 1 | Buffer enable |
| force_wr | input | 1 | Bus write strobe for the force bit |
| force_wdata | input | 1 | Value written to the force bit |
| force_rd_bit | output | 1 | Read value of the force bit (always 0) |
| timer_val | input | CAP_W | Current free-running timer value |
| cap_evt | input | NUM_CH | Per-channel capture event |
| acc_evt | input | NUM_CH | Per-channel qualified accumulator edge |
| cap_o | output | NUM_CH*CAP_W | Capture registers, channel 0 in the low bits |
| acc_o | output | NUM_CH*ACC_W | Live accumulators |
| hold_cap_o | output | NUM_CH*CAP_W | Capture holding registers |
| hold_acc_o | output | NUM_CH*ACC_W | Accumulator holding registers |

## Verification
The bench uses the default parameters: four channels, 16-bit capture words and 8-bit accumulators. With 8-bit counts, a run of a few hundred edges on one channel reaches the 0xFF ceiling, so saturation is tested directly, including a latch taken from a saturated count. Four channels allow mixed event patterns within one vector, so each latch is checked across every lane at once.

// File: rtl/cpl_pkg.sv
package cpl_pkg;

    localparam int unsigned DEF_NUM_CH = 4;
    localparam int unsigned DEF_CAP_W  = 16;
    localparam int unsigned DEF_ACC_W  = 8;

    // Outcome of one bus cycle on the force bit
    typedef enum logic [1:0] {
        FRC_IDLE    = 2'd0,
        FRC_FIRE    = 2'd1,
        FRC_BLOCKED = 2'd2,
        FRC_ZERO    = 2'd3
    } force_dec_e;

    typedef struct packed {
        logic wr;
        logic wbit;
        logic latch_en;
        logic buf_en;
    } force_req_t;

    function automatic force_dec_e decide_force(input force_req_t r);
        if (!r.wr)                     return FRC_IDLE;
        if (!r.wbit)                   return FRC_ZERO;
        if (!(r.latch_en && r.buf_en)) return FRC_BLOCKED;
        return FRC_FIRE;
    endfunction

endpackage

// File: rtl/cpl_force_ctrl.sv
module cpl_force_ctrl
    import cpl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mode_latch_en,
    input  logic mode_buf_en,
    input  logic force_wr,
    input  logic force_wdata,
    output logic force_latch,
    output logic force_rd_bit
);

    force_req_t req;
    force_dec_e dec;

    always_comb begin
        req.wr       = force_wr;
        req.wbit     = force_wdata;
        req.latch_en = mode_latch_en;
        req.buf_en   = mode_buf_en;
        dec          = decide_force(req);
        force_latch  = (dec == FRC_FIRE);
        force_rd_bit = 1'b0;
    end

    AST_NO_FORCE_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
        (force_wr && !force_wdata) |-> !force_latch); // R7

    AST_NO_FORCE_WITHOUT_WR: assert property (@(posedge clk) disable iff (rst)
        !force_wr |-> !force_latch); // R6

endmodule

// File: rtl/cpl_channel.sv
module cpl_channel #(
    parameter int unsigned CAP_W = 16,
    parameter int unsigned ACC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_evt,
    input  logic             acc_evt,
    input  logic [CAP_W-1:0] timer_val,
    input  logic             force_latch,
    output logic [CAP_W-1:0] cap_q,
    output logic [ACC_W-1:0] acc_q,
    output logic [CAP_W-1:0] hold_cap,
    output logic [ACC_W-1:0] hold_acc
);

    localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};

    logic [CAP_W-1:0] cap_next;
    logic [ACC_W-1:0] acc_inc;
    logic [ACC_W-1:0] acc_seen;

    always_comb begin
        cap_next = cap_evt ? timer_val : cap_q;
        acc_inc  = (acc_q == ACC_MAX) ? acc_q : acc_q + 1'b1;
        acc_seen = acc_evt ? acc_inc : acc_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q    <= '0;
            acc_q    <= '0;
            hold_cap <= '0;
            hold_acc <= '0;
        end else begin
            cap_q <= cap_next;
            if (force_latch) begin
                hold_cap <= cap_next;
                hold_acc <= acc_seen;
                acc_q    <= '0;
            end else begin
                acc_q <= acc_seen;
            end
        end
    end

    AST_ACC_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (acc_q == ACC_MAX && !force_latch) |=> (acc_q == ACC_MAX)); // R3

    AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (rst)
        force_latch |=> (acc_q == '0)); // R5

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !force_latch |=> ($stable(hold_cap) && $stable(hold_acc))); // R10

    AST_CAP_STABLE: assert property (@(posedge clk) disable iff (rst)
        !cap_evt |=> $stable(cap_q)); // R2

    AST_SAME_CYCLE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (force_latch && cap_evt) |=> (hold_cap == cap_q)); // R9

endmodule

// File: rtl/cpl_latch_unit.sv
module cpl_latch_unit
    import cpl_pkg::*;
#(
    parameter int unsigned NUM_CH = DEF_NUM_CH,
    parameter int unsigned CAP_W  = DEF_CAP_W,
    parameter int unsigned ACC_W  = DEF_ACC_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     mode_latch_en,
    input  logic                     mode_buf_en,
    input  logic                     force_wr,
    input  logic                     force_wdata,
    output logic                     force_rd_bit,
    input  logic [CAP_W-1:0]         timer_val,
    input  logic [NUM_CH-1:0]        cap_evt,
    input  logic [NUM_CH-1:0]        acc_evt,
    output logic [NUM_CH*CAP_W-1:0]  cap_o,
    output logic [NUM_CH*ACC_W-1:0]  acc_o,
    output logic [NUM_CH*CAP_W-1:0]  hold_cap_o,
    output logic [NUM_CH*ACC_W-1:0]  hold_acc_o
);

    logic force_latch;

    cpl_force_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .mode_latch_en(mode_latch_en),
        .mode_buf_en  (mode_buf_en),
        .force_wr     (force_wr),
        .force_wdata  (force_wdata),
        .force_latch  (force_latch),
        .force_rd_bit (force_rd_bit)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        cpl_channel #(
            .CAP_W(CAP_W),
            .ACC_W(ACC_W)
        ) u_chan (
            .clk        (clk),
            .rst        (rst),
            .cap_evt    (cap_evt[ch]),
            .acc_evt    (acc_evt[ch]),
            .timer_val  (timer_val),
            .force_latch(force_latch),
            .cap_q      (cap_o[ch*CAP_W +: CAP_W]),
            .acc_q      (acc_o[ch*ACC_W +: ACC_W]),
            .hold_cap   (hold_cap_o[ch*CAP_W +: CAP_W]),
            .hold_acc   (hold_acc_o[ch*ACC_W +: ACC_W])
        );
    end

    AST_MODES_GATE_LATCH: assert property (@(posedge clk) disable iff (rst)
        !(mode_latch_en && mode_buf_en) |=> ($stable(hold_cap_o) && $stable(hold_acc_o))); // R6

    AST_RD_BIT_ZERO: assert property (@(posedge clk) disable iff (rst)
        force_wr |-> (force_rd_bit == 1'b0)); // R8

endmodule

// File: tb/tb_cpl_latch_unit.sv
module tb_cpl_latch_unit;

    localparam int NCH = 4;
    localparam int CW  = 16;
    localparam int AW  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_latch_en = 0, mode_buf_en = 0, force_wr = 0, force_wdata = 0;
    logic force_rd_bit;
    logic [CW-1:0] timer_val = '0;
    logic [NCH-1:0] cap_evt = '0, acc_evt = '0;
    logic [NCH*CW-1:0] cap_o, hold_cap_o;
    logic [NCH*AW-1:0] acc_o, hold_acc_o;

    always #2 clk = ~clk;

    cpl_latch_unit dut (
        .clk(clk), .rst(rst),
        .mode_latch_en(mode_latch_en), .mode_buf_en(mode_buf_en),
        .force_wr(force_wr), .force_wdata(force_wdata),
        .force_rd_bit(force_rd_bit), .timer_val(timer_val),
        .cap_evt(cap_evt), .acc_evt(acc_evt),
        .cap_o(cap_o), .acc_o(acc_o),
        .hold_cap_o(hold_cap_o), .hold_acc_o(hold_acc_o)
    );

    int checks = 0;
    int fails  = 0;

    logic [CW-1:0] m_cap [NCH];
    logic [AW-1:0] m_acc [NCH];
    logic [CW-1:0] m_hc  [NCH];
    logic [AW-1:0] m_ha  [NCH];

    // vector: {latch_en, buf_en, wr, wdata, cap_evt[3:0], acc_evt[3:0], timer[15:0]}
    localparam logic [27:0] VEC [16] = '{
        28'h0FF1000, 28'h0051001, 28'h0131002, 28'hC001003,
        28'hF001004, 28'h02F1005, 28'h3001006, 28'h8011007,
        28'h4021008, 28'hE001009, 28'hF88100A, 28'h044100B,
        28'hB0F100C, 28'h700100D, 28'hF11100E, 28'hC00100F
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        for (int c = 0; c < NCH; c++) begin
            check({tag, " R2 cap"}, 32'(cap_o[c*CW +: CW]), 32'(m_cap[c]));
            check({tag, " R3 acc"}, 32'(acc_o[c*AW +: AW]), 32'(m_acc[c]));
            check({tag, " R4 hold_cap"}, 32'(hold_cap_o[c*CW +: CW]), 32'(m_hc[c]));
            check({tag, " R4 hold_acc"}, 32'(hold_acc_o[c*AW +: AW]), 32'(m_ha[c]));
        end
        check({tag, " R8 rd_bit"}, 32'(force_rd_bit), 32'd0);
    endtask

    task automatic step(input logic [27:0] v, input string tag);
        logic fire;
        logic [CW-1:0] nc;
        logic [AW-1:0] na;
        @(negedge clk);
        {mode_latch_en, mode_buf_en, force_wr, force_wdata} = v[27:24];
        cap_evt   = v[23:20];
        acc_evt   = v[19:16];
        timer_val = v[15:0];
        fire = &v[27:24];
        for (int c = 0; c < NCH; c++) begin
            nc = v[20+c] ? v[15:0] : m_cap[c];
            na = (v[16+c] && m_acc[c] != 8'hFF) ? m_acc[c] + 8'd1 : m_acc[c];
            m_cap[c] = nc;
            if (fire) begin
                m_hc[c]  = nc;
                m_ha[c]  = na;
                m_acc[c] = '0;
            end else begin
                m_acc[c] = na;
            end
        end
        @(posedge clk);
        #1;
        compare_all(tag);
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            m_cap[c] = '0; m_acc[c] = '0; m_hc[c] = '0; m_ha[c] = '0;
        end
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        compare_all("R1 in reset");
        @(negedge clk);
        rst = 1'b0;
        step(28'h0000000, "R1 after reset");

        for (int i = 0; i < 16; i++) begin
            step(VEC[i], $sformatf("vec%0d", i));
            if (i == 10) begin
                // same-cycle capture and force on channel 3
                check("R9 same-cycle capture", 32'(hold_cap_o[3*CW +: CW]), 32'h100A);
                check("R5 cleared after force", 32'(acc_o), 32'd0);
            end
        end

        // R6: blocked write not remembered, then enables alone
        step(28'h00F2000, "R6 prep");
        step(28'h3000000, "R6 blocked");
        step(28'hC000000, "R6 enables only");
        check("R6 hold_acc untouched", 32'(hold_acc_o[0 +: AW]), 32'(m_ha[0]));
        check("R6 acc kept", 32'(acc_o[0 +: AW]), 32'h01);

        // R7: zero data
        step(28'hE000000, "R7 zero write");
        check("R7 acc kept", 32'(acc_o[0 +: AW]), 32'h01);

        // R3: saturation on channel 1
        for (int k = 0; k < 300; k++) step(28'h0020000, "R3 saturate");
        check("R3 ceiling", 32'(acc_o[1*AW +: AW]), 32'hFF);
        step(28'hF020000, "R9 saturated latch");
        check("R9 latched ceiling", 32'(hold_acc_o[1*AW +: AW]), 32'hFF);
        check("R5 cleared", 32'(acc_o[1*AW +: AW]), 32'h00);
        step(28'h0000000, "R10 idle");
        check("R10 hold kept", 32'(hold_acc_o[1*AW +: AW]), 32'hFF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule